// File: doc/BRIEF.md
# Power Rail Fault Protection Supervisor

This block decides, cycle by cycle, which outputs of a multi-channel step-down regulator may run. It takes digitized input-supply readings from several sense points, an over-temperature flag, per-channel overvoltage and overcurrent comparator flags, and a host enable per channel. From these it drives one registered enable per channel. Supply and temperature faults turn every channel off. Output faults turn off only the channel that reported them.

Supply readings and both thresholds are unsigned codes on a common scale of 100 mV per LSB. A reading below the warning level raises a warning and a notification output, but shuts nothing down. A reading below the fault level locks every channel off. The lock releases only after every sense point is back strictly above the warning level, which gives hysteresis. The release is either automatic or left to the host, depending on a configuration input. An overcurrent trip starts a timer that counts a millisecond tick, and the channel returns by itself when the timer expires. An overvoltage trip or an over-temperature trip stays latched until the host drops the enable. All fault events are also kept in sticky status bits, which only a host clear pulse resets.

Top module: `rail_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, `ch_en`, `warn_irq` and all sticky status outputs are 0.
- R2: A channel whose `host_en` bit is low has its `ch_en` bit low on the next cycle, regardless of any fault state.
- R3: If any sense point reads strictly below `fault_lvl`, the matching `uv_fault` bit is set and every `ch_en` bit is 0 two cycles later. Sense point j occupies bits [j*VW +: VW] of `vin_bus`.
- R4: If a sense point reads strictly below `warn_lvl`, the matching `uv_warn` bit is set within one cycle and `warn_irq` is high two cycles later. A reading at or above `fault_lvl` does not turn off any channel.
- R5: When `auto_restart` is 1, the undervoltage lock holds while any sense point reads at or below `warn_lvl`. Once all points are strictly above it, the channels come back two cycles later.
- R6: When `auto_restart` is 0, the undervoltage lock persists after recovery until all `host_en` bits have been low for one cycle.
- R7: `overtemp` high turns every channel off two cycles later and sets `ot_fault`. The shutdown stays latched after `overtemp` falls, until all `host_en` bits are low.
- R8: `ov_flag[i]` high with `host_en[i]` high turns off only channel i two cycles later and sets `ov_fault[i]`. The channel stays off until `host_en[i]` goes low.
- R9: `oc_flag[i]` on a running channel turns off only channel i and sets `oc_fault[i]`. Channel i returns two cycles after the RESTART_MS-th `tick_ms` pulse that follows the trip.
- R10: A global shutdown while an overcurrent timer runs cancels that timer. The channel returns with the global recovery, without waiting for ticks.
- R11: Sticky status bits hold until `clr_pulse`. A clear resets the bits whose condition is absent in that cycle, and a condition present in that cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| vin_bus | input | NSENSE*VW | Supply readings, point j at bits [j*VW +: VW] |
| warn_lvl | input | VW | Warning and recovery threshold code |
| fault_lvl | input | VW | Undervoltage fault threshold code |
| auto_restart | input | 1 | 1: release undervoltage lock automatically |
| overtemp | input | 1 | Over-temperature flag |
| ov_flag | input | NCH | Per-channel overvoltage flags |
| oc_flag | input | NCH | Per-channel overcurrent flags |
| host_en | input | NCH | Host enable per channel |
| clr_pulse | input | 1 | Clears sticky status bits |
| ch_en | output | NCH | Registered channel enables |
| warn_irq | output | 1 | Host notification of an undervoltage warning |
| uv_warn | output | NSENSE | Sticky warning per sense point |
| uv_fault | output | NSENSE | Sticky undervoltage fault per sense point |
| ot_fault | output | 1 | Sticky over-temperature fault |
| ov_fault | output | NCH | Sticky overvoltage per channel |
| oc_fault | output | NCH | Sticky overcurrent per channel |

## Verification
Each sense point is swept through every code of a 6-bit reading while the other point is held safe. This places each value relative to both thresholds, so the sweep shows whether warning, fault and shutdown follow strict less-than comparisons at each boundary. A walk across the hysteresis band (below fault, between the levels, equal to warning, one above) shows whether release waits for the warning level. Timed overcurrent sequences check the channel at tick RESTART_MS-1 and at tick RESTART_MS, which exposes off-by-one timers. Separate sequences with a latched overvoltage and over-temperature fault show whether the shutdown scope is per channel or global.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    CH_RUN     = 2'd0,
    CH_OV_HOLD = 2'd1,
    CH_OC_WAIT = 2'd2
  } ch_state_t;
endpackage

// File: rtl/rg_uv_monitor.sv
module rg_uv_monitor #(
  parameter int NSENSE = 2,
  parameter int VW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSENSE*VW-1:0] vin_bus,
  input  logic [VW-1:0]        warn_lvl,
  input  logic [VW-1:0]        fault_lvl,
  input  logic                 auto_restart,
  input  logic                 dev_off,
  input  logic                 clr_pulse,
  output logic [NSENSE-1:0]    warn_stk,
  output logic [NSENSE-1:0]    fault_stk,
  output logic                 uv_lock
);
  logic [NSENSE-1:0] below_warn, below_fault, above_warn;

  for (genvar j = 0; j < NSENSE; j++) begin : g_pt
    logic [VW-1:0] rd;
    assign rd             = vin_bus[j*VW +: VW];
    assign below_warn[j]  = rd < warn_lvl;
    assign below_fault[j] = rd < fault_lvl;
    assign above_warn[j]  = rd > warn_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_stk  <= '0;
      fault_stk <= '0;
      uv_lock   <= 1'b0;
    end else begin
      warn_stk  <= (clr_pulse ? '0 : warn_stk) | below_warn;
      fault_stk <= (clr_pulse ? '0 : fault_stk) | below_fault;
      if (|below_fault)
        uv_lock <= 1'b1;
      else if ((&above_warn) && (auto_restart || dev_off))
        uv_lock <= 1'b0;
    end
  end
endmodule

// File: rtl/rg_chan_guard.sv
module rg_chan_guard #(
  parameter int RESTART_MS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic host_en,
  input  logic glob_off,
  input  logic ov,
  input  logic oc,
  output logic off
);
  import rg_pkg::*;
  localparam int CW = (RESTART_MS > 1) ? $clog2(RESTART_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(RESTART_MS - 1);

  ch_state_t     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= CH_RUN;
      cnt <= '0;
    end else if (!host_en) begin
      st  <= CH_RUN;
      cnt <= '0;
    end else begin
      unique case (st)
        CH_RUN: begin
          if (ov) st <= CH_OV_HOLD;
          else if (oc && !glob_off) begin
            st  <= CH_OC_WAIT;
            cnt <= '0;
          end
        end
        CH_OV_HOLD: st <= CH_OV_HOLD;
        CH_OC_WAIT: begin
          if (ov) st <= CH_OV_HOLD;
          else if (glob_off) begin
            st  <= CH_RUN;
            cnt <= '0;
          end else if (tick_ms) begin
            if (cnt == LAST) begin
              st  <= CH_RUN;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= CH_RUN;
      endcase
    end
  end

  assign off = (st != CH_RUN);
endmodule

// File: rtl/rail_guard.sv
module rail_guard #(
  parameter int NCH        = 4,
  parameter int NSENSE     = 2,
  parameter int VW         = 8,
  parameter int RESTART_MS = 200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_ms,
  input  logic [NSENSE*VW-1:0] vin_bus,
  input  logic [VW-1:0]        warn_lvl,
  input  logic [VW-1:0]        fault_lvl,
  input  logic                 auto_restart,
  input  logic                 overtemp,
  input  logic [NCH-1:0]       ov_flag,
  input  logic [NCH-1:0]       oc_flag,
  input  logic [NCH-1:0]       host_en,
  input  logic                 clr_pulse,
  output logic [NCH-1:0]       ch_en,
  output logic                 warn_irq,
  output logic [NSENSE-1:0]    uv_warn,
  output logic [NSENSE-1:0]    uv_fault,
  output logic                 ot_fault,
  output logic [NCH-1:0]       ov_fault,
  output logic [NCH-1:0]       oc_fault
);
  logic           dev_off, uv_lock, ot_lock, glob_off;
  logic [NCH-1:0] ch_off;

  assign dev_off  = ~|host_en;
  assign glob_off = uv_lock | ot_lock;

  rg_uv_monitor #(.NSENSE(NSENSE), .VW(VW)) u_uv (
    .clk(clk), .rst(rst), .vin_bus(vin_bus), .warn_lvl(warn_lvl),
    .fault_lvl(fault_lvl), .auto_restart(auto_restart), .dev_off(dev_off),
    .clr_pulse(clr_pulse), .warn_stk(uv_warn), .fault_stk(uv_fault),
    .uv_lock(uv_lock)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    rg_chan_guard #(.RESTART_MS(RESTART_MS)) u_guard (
      .clk(clk), .rst(rst), .tick_ms(tick_ms), .host_en(host_en[i]),
      .glob_off(glob_off), .ov(ov_flag[i]), .oc(oc_flag[i] & ~ch_off[i]),
      .off(ch_off[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ot_lock  <= 1'b0;
      ot_fault <= 1'b0;
      ov_fault <= '0;
      oc_fault <= '0;
      warn_irq <= 1'b0;
      ch_en    <= '0;
    end else begin
      if (overtemp)     ot_lock <= 1'b1;
      else if (dev_off) ot_lock <= 1'b0;
      ot_fault <= (clr_pulse ? 1'b0 : ot_fault) | overtemp;
      ov_fault <= (clr_pulse ? '0 : ov_fault) | ov_flag;
      oc_fault <= (clr_pulse ? '0 : oc_fault) | oc_flag;
      warn_irq <= |uv_warn;
      ch_en    <= host_en & ~ch_off & {NCH{~glob_off}};
    end
  end
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int NCH    = 4,
  parameter int NSENSE = 2,
  parameter int VW     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NSENSE*VW-1:0] vin_bus,
  input logic [VW-1:0]        warn_lvl,
  input logic [VW-1:0]        fault_lvl,
  input logic                 overtemp,
  input logic [NCH-1:0]       ov_flag,
  input logic [NCH-1:0]       host_en,
  input logic                 clr_pulse,
  input logic [NCH-1:0]       ch_en,
  input logic                 warn_irq,
  input logic [NSENSE-1:0]    uv_fault
);
  logic [NSENSE-1:0] lo_w, lo_f;
  for (genvar j = 0; j < NSENSE; j++) begin : g_pt
    assign lo_w[j] = vin_bus[j*VW +: VW] < warn_lvl;
    assign lo_f[j] = vin_bus[j*VW +: VW] < fault_lvl;

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
      (uv_fault[j] && !clr_pulse) |=> uv_fault[j]); // R11
  end

  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (|lo_f) |=> ##1 (ch_en == '0)); // R3
  AST_WARN_NOTIFY: assert property (@(posedge clk) disable iff (rst)
    (|lo_w) |=> ##1 warn_irq); // R4
  AST_OT_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    overtemp |=> ##1 (ch_en == '0)); // R7

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_HOST_GATE: assert property (@(posedge clk) disable iff (rst)
      !host_en[i] |=> !ch_en[i]); // R2
    AST_OV_LOCAL: assert property (@(posedge clk) disable iff (rst)
      (ov_flag[i] && host_en[i]) |=> ##1 !ch_en[i]); // R8
  end
endmodule

bind rail_guard rg_checker #(.NCH(NCH), .NSENSE(NSENSE), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .vin_bus(vin_bus), .warn_lvl(warn_lvl),
  .fault_lvl(fault_lvl), .overtemp(overtemp), .ov_flag(ov_flag),
  .host_en(host_en), .clr_pulse(clr_pulse), .ch_en(ch_en),
  .warn_irq(warn_irq), .uv_fault(uv_fault)
);

// File: tb/rail_guard_test.sv
module rail_guard_test;
  localparam int NCH = 4, NS = 2, VW = 6, RMS = 5;
  localparam logic [VW-1:0] WARN = 6'd20, FLT = 6'd15, SAFE = 6'd40;

  logic clk = 0, rst = 1, tick_ms = 0, auto_restart = 1, overtemp = 0, clr_pulse = 0;
  logic [NS*VW-1:0] vin_bus;
  logic [VW-1:0] warn_lvl = WARN, fault_lvl = FLT;
  logic [NCH-1:0] ov_flag = '0, oc_flag = '0, host_en = '0;
  logic [NCH-1:0] ch_en, ov_fault, oc_fault;
  logic warn_irq, ot_fault;
  logic [NS-1:0] uv_warn, uv_fault;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rail_guard #(.NCH(NCH), .NSENSE(NS), .VW(VW), .RESTART_MS(RMS)) uut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .vin_bus(vin_bus), .warn_lvl(warn_lvl),
    .fault_lvl(fault_lvl), .auto_restart(auto_restart), .overtemp(overtemp),
    .ov_flag(ov_flag), .oc_flag(oc_flag), .host_en(host_en), .clr_pulse(clr_pulse),
    .ch_en(ch_en), .warn_irq(warn_irq), .uv_warn(uv_warn), .uv_fault(uv_fault),
    .ot_fault(ot_fault), .ov_fault(ov_fault), .oc_fault(oc_fault));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_pulse = 1; step(1); clr_pulse = 0; step(2);
  endtask

  task automatic tick();
    tick_ms = 1; step(1); tick_ms = 0; step(1);
  endtask

  initial begin
    vin_bus = {SAFE, SAFE};
    step(3);
    check("R1 ch_en", ch_en, 0);
    check("R1 status", {warn_irq, uv_warn, uv_fault, ot_fault, ov_fault, oc_fault}, 0);
    rst = 0; host_en = 4'hF;
    step(2);
    check("R1 run after reset", ch_en, 4'hF);

    // R2 host gating
    host_en = 4'b1010; step(2);
    check("R2 host gate", ch_en, 4'b1010);
    host_en = 4'hF; step(2);
    check("R2 host restore", ch_en, 4'hF);

    // R3 / R4 sweep over every code at each sense point
    for (int pt = 0; pt < NS; pt++) begin
      for (int v = 0; v < 64; v++) begin
        vin_bus = {SAFE, SAFE}; step(3); clear_all();
        vin_bus[pt*VW +: VW] = VW'(v); step(3);
        check("R4 warn bit", uv_warn[pt], v < WARN);
        check("R4 warn_irq", warn_irq, v < WARN);
        check("R3 fault bit", uv_fault[pt], v < FLT);
        check("R3 R4 shutdown", ch_en, (v < FLT) ? 4'h0 : 4'hF);
      end
    end
    vin_bus = {SAFE, SAFE}; step(3); clear_all();

    // R5 hysteresis with auto restart
    vin_bus[VW-1:0] = 6'd10; step(3);
    check("R5 locked", ch_en, 0);
    vin_bus[VW-1:0] = 6'd18; step(3);
    check("R5 between levels", ch_en, 0);
    vin_bus[VW-1:0] = WARN; step(3);
    check("R5 equal warn", ch_en, 0);
    vin_bus[VW-1:0] = WARN + 6'd1; step(3);
    check("R5 released", ch_en, 4'hF);

    // R6 no auto restart
    auto_restart = 0;
    vin_bus[VW +: VW] = 6'd5; step(3);
    vin_bus[VW +: VW] = SAFE; step(4);
    check("R6 held", ch_en, 0);
    host_en = 0; step(2); host_en = 4'hF; step(3);
    check("R6 host release", ch_en, 4'hF);
    auto_restart = 1; clear_all();

    // R7 over-temperature latch
    overtemp = 1; step(1); overtemp = 0; step(2);
    check("R7 all off", ch_en, 0);
    check("R7 sticky", ot_fault, 1);
    step(3);
    check("R7 latched", ch_en, 0);
    host_en = 0; step(2); host_en = 4'hF; step(3);
    check("R7 host release", ch_en, 4'hF);

    // R8 overvoltage local latch
    ov_flag = 4'b1000; step(1); ov_flag = 0; step(2);
    check("R8 local off", ch_en, 4'b0111);
    check("R8 sticky", ov_fault, 4'b1000);
    step(4);
    check("R8 latched", ch_en, 4'b0111);
    host_en = 4'b0111; step(2); host_en = 4'hF; step(3);
    check("R8 host release", ch_en, 4'hF);

    // R9 overcurrent timed restart
    oc_flag = 4'b0010; step(1); oc_flag = 0; step(2);
    check("R9 local off", ch_en, 4'b1101);
    check("R9 sticky", oc_fault, 4'b0010);
    for (int k = 0; k < RMS - 1; k++) tick();
    step(1);
    check("R9 before last tick", ch_en, 4'b1101);
    tick_ms = 1; step(1); tick_ms = 0; step(1);
    check("R9 restarted", ch_en, 4'hF);

    // R10 global fault cancels timer
    oc_flag = 4'b0100; step(1); oc_flag = 0; step(1);
    tick(); tick();
    vin_bus[VW-1:0] = 6'd3; step(3);
    check("R10 global off", ch_en, 0);
    vin_bus[VW-1:0] = SAFE; step(3);
    check("R10 back without ticks", ch_en, 4'hF);

    // R11 sticky hold and clear
    step(5);
    check("R11 held", {ot_fault, ov_fault, oc_fault}, {1'b1, 4'b1000, 4'b0110});
    check("R11 uv held", uv_fault, 2'b01);
    clear_all();
    check("R11 cleared", {warn_irq, uv_warn, uv_fault, ot_fault, ov_fault, oc_fault}, 0);
    vin_bus[VW-1:0] = 6'd17; clr_pulse = 1; step(1); clr_pulse = 0; step(1);
    check("R11 set beats clear", uv_warn, 2'b01);
    vin_bus[VW-1:0] = SAFE; step(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule